// File: doc/BRIEF.md
# Block Transmit Remaining-Length Counter

This block keeps track of how many bytes are still owed in a block transmit transfer on a serial port. Software writes a 16-bit length word. The low ten bits hold the transfer length minus one. That write arms the counter and starts the transfer at once. Each time the serial transmitter reports that it has taken a byte, the count steps down by one. A read at any moment returns the bytes still outstanding, again coded as remaining-minus-one.

A byte strobe that arrives while the count is zero is the last byte. The counter then wraps to all ones, the busy flag drops and a single-cycle done pulse is raised. The readback holds all ones until software loads a new length. A new write during a running transfer abandons the old count and restarts with the new one. The shifter, baud logic and data buffer sit outside this block and reach it only through the byte strobe.

Top module: `blk_tx_remain`

## Requirements
- R1: While reset is held, and in the first cycle after it, `rd_data` reads 0x03FF and `busy` and `done` are low.
- R2: A cycle with `wr_en` high loads bits 9:0 of `wr_data` into the count. From the next cycle `rd_data` returns that value and `busy` is high.
- R3: Bits 15:10 of `wr_data` are discarded, and bits 15:10 of `rd_data` always read zero.
- R4: A `byte_sent` pulse while `busy` is high and the count is nonzero lowers the count by exactly one in the next cycle. `busy` stays high.
- R5: A `byte_sent` pulse while `busy` is high and the count is zero sets the count to 0x03FF and clears `busy` in the next cycle. A load of N therefore completes after exactly N+1 strobes.
- R6: While `busy` is low, `byte_sent` has no effect: `rd_data` stays at its value and `busy` stays low.
- R7: `done` is high for exactly one cycle, the cycle after the completing strobe, and never at any other time.
- R8: A write during an active transfer restarts it with the new count. `busy` stays high and no `done` pulse is raised.
- R9: When `wr_en` and `byte_sent` are high in the same cycle, the write takes effect and the strobe is discarded, even if that strobe would have completed the transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Write word; bits 9:0 hold length minus one |
| rd_data | output | 16 | Remaining count minus one; reserved bits read zero |
| byte_sent | input | 1 | One-cycle pulse per byte taken by the transmitter |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the final byte |

## Verification
Two events can fall in the same cycle: a software reload and a byte strobe. The bench provokes this collision in two states. In the first, the count is mid-transfer. In the second, the count is zero, so the strobe alone would have finished the transfer. In both cases the readback must show the newly written value, with `busy` still high and no `done` pulse. A decremented value, or a wrap to all ones, reveals that the strobe was wrongly let through.

// File: rtl/blk_tx_remain_pkg.sv
package blk_tx_remain_pkg;

    localparam int BTR_REG_W = 16;
    localparam int BTR_CNT_W = 10;

    // Action applied to the count register in a given cycle.
    typedef enum logic [1:0] {
        OP_HOLD   = 2'd0,
        OP_LOAD   = 2'd1,
        OP_STEP   = 2'd2,
        OP_FINISH = 2'd3
    } btr_op_e;

    // Per-cycle command handed from the decoder to the count core.
    typedef struct packed {
        logic req;
        logic strobe;
    } btr_evt_t;

    // A write always wins; a strobe only counts while a transfer is running.
    function automatic btr_op_e btr_classify(input btr_evt_t ev,
                                             input logic     active,
                                             input logic     at_zero);
        btr_op_e op;
        if (ev.req)
            op = OP_LOAD;
        else if (ev.strobe && active && at_zero)
            op = OP_FINISH;
        else if (ev.strobe && active)
            op = OP_STEP;
        else
            op = OP_HOLD;
        return op;
    endfunction

endpackage

// File: rtl/blk_tx_wr_decode.sv
module blk_tx_wr_decode
    import blk_tx_remain_pkg::*;
#(
    parameter int REG_W = BTR_REG_W,
    parameter int CNT_W = BTR_CNT_W
) (
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             byte_sent,
    output btr_evt_t         evt,
    output logic [REG_W-1:0] load_word
);

    localparam int RSV_W = REG_W - CNT_W;

    logic [REG_W-1:0] field_mask;

    generate
        if (RSV_W > 0) begin : g_rsv
            assign field_mask = {{RSV_W{1'b0}}, {CNT_W{1'b1}}};
        end else begin : g_norsv
            assign field_mask = {REG_W{1'b1}};
        end
    endgenerate

    // Reserved bits never reach the register.
    assign load_word  = wr_data & field_mask;
    assign evt.req    = wr_en;
    assign evt.strobe = byte_sent;

endmodule

// File: rtl/blk_tx_count_core.sv
module blk_tx_count_core
    import blk_tx_remain_pkg::*;
#(
    parameter int REG_W = BTR_REG_W,
    parameter int CNT_W = BTR_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  btr_op_e          op,
    input  logic [REG_W-1:0] load_word,
    output logic [REG_W-1:0] count_word,
    output logic             at_zero
);

    localparam logic [CNT_W-1:0] FIELD_ONES = {CNT_W{1'b1}};
    localparam logic [REG_W-1:0] IDLE_WORD  = REG_W'(FIELD_ONES);

    logic [REG_W-1:0] word_q;
    logic [CNT_W-1:0] field;
    logic [CNT_W-1:0] field_dec;

    assign field     = word_q[CNT_W-1:0];
    assign field_dec = field - 1'b1;
    assign at_zero   = (field == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= IDLE_WORD;
        end else begin
            unique case (op)
                OP_LOAD:   word_q <= load_word;
                OP_STEP:   word_q <= REG_W'(field_dec);
                OP_FINISH: word_q <= IDLE_WORD;
                default:   word_q <= word_q;
            endcase
        end
    end

    assign count_word = word_q;

endmodule

// File: rtl/blk_tx_status.sv
module blk_tx_status
    import blk_tx_remain_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  btr_op_e op,
    output logic    active,
    output logic    done_pulse
);

    logic active_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            done_q <= (op == OP_FINISH);
            unique case (op)
                OP_LOAD:   active_q <= 1'b1;
                OP_FINISH: active_q <= 1'b0;
                default:   active_q <= active_q;
            endcase
        end
    end

    assign active     = active_q;
    assign done_pulse = done_q;

endmodule

// File: rtl/blk_tx_remain.sv
module blk_tx_remain
    import blk_tx_remain_pkg::*;
#(
    parameter int REG_W = BTR_REG_W,
    parameter int CNT_W = BTR_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             byte_sent,
    output logic             busy,
    output logic             done
);

    btr_evt_t         evt;
    btr_op_e          op;
    logic [REG_W-1:0] load_word;
    logic [REG_W-1:0] count_word;
    logic             at_zero;
    logic             active;
    logic             done_pulse;

    blk_tx_wr_decode #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dec (
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .byte_sent (byte_sent),
        .evt       (evt),
        .load_word (load_word)
    );

    assign op = btr_classify(evt, active, at_zero);

    blk_tx_count_core #(.REG_W(REG_W), .CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .load_word  (load_word),
        .count_word (count_word),
        .at_zero    (at_zero)
    );

    blk_tx_status u_stat (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .active     (active),
        .done_pulse (done_pulse)
    );

    assign rd_data = count_word;
    assign busy    = active;
    assign done    = done_pulse;

endmodule

// File: rtl/blk_tx_remain_chk.sv
module blk_tx_remain_chk #(
    parameter int REG_W = 16,
    parameter int CNT_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             byte_sent,
    input logic             busy,
    input logic             done
);

    localparam logic [REG_W-1:0] ALL_FIELD = REG_W'({CNT_W{1'b1}});

    logic [CNT_W-1:0] rd_field;
    logic [CNT_W-1:0] wr_field;
    assign rd_field = rd_data[CNT_W-1:0];
    assign wr_field = wr_data[CNT_W-1:0];

    // R2, R8
    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rd_data == REG_W'($past(wr_field))) && busy && !done);

    // R3
    assert_rsv_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rd_data[REG_W-1:CNT_W] == '0);

    // R4
    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && byte_sent && busy && rd_field != '0)
        |=> (rd_field == $past(rd_field) - 1'b1) && busy);

    // R5
    assert_finish_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && byte_sent && busy && rd_field == '0)
        |=> (rd_data == ALL_FIELD) && !busy && done);

    // R6
    assert_idle_ignore_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !busy) |=> $stable(rd_data) && !busy);

    // R7
    assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_cause_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy && $past(busy) && $past(byte_sent) && !$past(wr_en));

endmodule

bind blk_tx_remain blk_tx_remain_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .byte_sent (byte_sent),
    .busy      (busy),
    .done      (done)
);

// File: tb/sim_blk_tx_remain.sv
module sim_blk_tx_remain;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        byte_sent = 1'b0;
    logic        busy;
    logic        done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    blk_tx_remain u0 (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .byte_sent (byte_sent),
        .busy      (busy),
        .done      (done)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input logic [15:0] exp_rd,
                               input logic exp_busy, input logic exp_done);
        check(req, "rd_data", 32'(rd_data), 32'(exp_rd));
        check(req, "busy", 32'(busy), 32'(exp_busy));
        check(req, "done", 32'(done), 32'(exp_done));
    endtask

    // Apply inputs for one clock edge; outputs are sampled 1 time unit after it.
    task automatic cycle(input logic w, input logic [15:0] d, input logic s);
        wr_en     = w;
        wr_data   = d;
        byte_sent = s;
        @(posedge clk);
        #1;
        wr_en     = 1'b0;
        wr_data   = '0;
        byte_sent = 1'b0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        check_state("R1", 16'h03FF, 1'b0, 1'b0);
        rst = 1'b0;
        cycle(1'b0, '0, 1'b0);
        check_state("R1", 16'h03FF, 1'b0, 1'b0);
    endtask

    // Load n, drain with n+1 strobes, optionally with idle gaps between them.
    task automatic t_drain(input int n, input int gap);
        cycle(1'b1, 16'(n), 1'b0);
        check_state("R2", 16'(n), 1'b1, 1'b0);
        for (int k = n; k > 0; k--) begin
            cycle(1'b0, '0, 1'b1);
            if (k <= 3 || k == n)
                check_state("R4", 16'(k - 1), 1'b1, 1'b0);
            for (int g = 0; g < gap; g++) begin
                cycle(1'b0, '0, 1'b0);
                if (g == 0)
                    check_state("R4", 16'(k - 1), 1'b1, 1'b0);
            end
        end
        cycle(1'b0, '0, 1'b1);
        check_state("R5", 16'h03FF, 1'b0, 1'b1);
        cycle(1'b0, '0, 1'b0);
        check_state("R7", 16'h03FF, 1'b0, 1'b0);
    endtask

    task automatic t_reserved();
        cycle(1'b1, 16'hFC05, 1'b0);
        check_state("R3", 16'h0005, 1'b1, 1'b0);
        cycle(1'b1, 16'hA800, 1'b0);
        check_state("R3", 16'h0000, 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b1);
        check_state("R3", 16'h03FF, 1'b0, 1'b1);
        cycle(1'b0, '0, 1'b0);
    endtask

    task automatic t_idle_strobes();
        for (int i = 0; i < 4; i++) begin
            cycle(1'b0, '0, 1'b1);
            check_state("R6", 16'h03FF, 1'b0, 1'b0);
        end
    endtask

    task automatic t_restart();
        cycle(1'b1, 16'd6, 1'b0);
        cycle(1'b0, '0, 1'b1);
        cycle(1'b0, '0, 1'b1);
        check_state("R8", 16'd4, 1'b1, 1'b0);
        cycle(1'b1, 16'd2, 1'b0);
        check_state("R8", 16'd2, 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b1);
        check_state("R8", 16'd1, 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b1);
        cycle(1'b0, '0, 1'b1);
        check_state("R8", 16'h03FF, 1'b0, 1'b1);
        cycle(1'b0, '0, 1'b0);
    endtask

    task automatic t_collision();
        cycle(1'b1, 16'd5, 1'b0);
        cycle(1'b1, 16'd9, 1'b1);
        check_state("R9", 16'd9, 1'b1, 1'b0);
        cycle(1'b1, 16'd0, 1'b0);
        check_state("R9", 16'd0, 1'b1, 1'b0);
        cycle(1'b1, 16'd2, 1'b1);
        check_state("R9", 16'd2, 1'b1, 1'b0);
        cycle(1'b0, '0, 1'b0);
        check_state("R9", 16'd2, 1'b1, 1'b0);
        t_drain_rest(2);
    endtask

    task automatic t_drain_rest(input int n);
        for (int k = n; k >= 0; k--) cycle(1'b0, '0, 1'b1);
        check_state("R5", 16'h03FF, 1'b0, 1'b1);
        cycle(1'b0, '0, 1'b0);
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_drain(3, 0);
        t_drain(0, 0);
        t_drain(4, 2);
        t_reserved();
        t_idle_strobes();
        t_restart();
        t_collision();
        t_drain(1023, 0);
        t_idle_strobes();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule